// File: doc/BRIEF.md
# Kernel Launch Register Interface

This block is the host-facing register window of a compute dispatcher. A host stages a kernel's grid description (three global sizes and three workgroup sizes) as raw bytes in a descriptor store, then writes the launch register. The launch claims the kernel slot that matches the next launch identifier and snapshots the grid. It works out the workgroup count of each dimension by rounded-up division, multiplies the three counts, and queues the identifier for the downstream workgroup scheduler.

The bus is a plain request/response port. Each request carries an address, a size code and write data, and each one receives a response a fixed number of cycles later. The scheduler side pops identifiers from the pending queue, reads a slot's counts through a select port, and hands a slot back with a release strobe once its work is finished. An outstanding-kernel counter drives the dispatch-active flag, which the host sees in bit 0 of the launch register.

Top module: `kl_launch_regs`

## Requirements
- R1: Every accepted request, read or write, produces exactly one `rsp_valid` pulse RSP_LAT cycles after its request cycle. Writes return zero data.
- R2: Descriptor bytes live at window addresses 8 and up: address a selects descriptor byte a-8. Size code 0/1/2/3 moves 1/2/4/8 bytes, and byte lane i carries descriptor byte a-8+i. Lanes past the store end are dropped on write and read as zero.
- R3: An 8-byte read (size code 3) at address 0 returns the dispatch-active flag in bit 0 and zero in every other bit. Reads at address 0 with other sizes return zero. Reads at addresses 1 to 7 return zero, and writes there have no effect.
- R4: A write to address 0 launches a kernel whatever its data and size code.
- R5: The descriptor layout is little-endian, DIM_W bits per field. Global sizes x, y, z sit at descriptor bytes 0, 2, 4 and workgroup sizes x, y, z at bytes 6, 8, 10. Each dimension's count is the global size divided by the workgroup size, rounded up. A workgroup size of zero counts as one, and a global size of zero gives a count of zero.
- R6: The slot total is the product of the three dimension counts, 3*DIM_W bits wide.
- R7: Launch identifiers start at 0, rise by one per accepted launch and wrap modulo SLOTS. The identifier is also the slot index. It enters the pending queue once its counts are stored, and `pend_pop` removes entries in launch order.
- R8: `launch_busy` is high for DIM_W+1 cycles, starting the cycle after an accepted launch. A launch attempted while busy is dropped, `launch_err` pulses for one cycle, and no identifier is consumed.
- R9: A launch whose target slot is still live is dropped with a one-cycle `launch_err` pulse. Nothing is queued and no identifier is consumed.
- R10: An accepted launch raises `dispatch_active`. A release of a live slot frees it and lowers the outstanding count, and the flag falls when the count reaches zero. A release of a slot that is not live is ignored.
- R11: `slot_sel` shows that slot's live flag, three counts and total on the slot outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address in the window |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata | input | 64 | Write data, lane i = byte i |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 64 | Read data |
| launch_busy | output | 1 | Grid division in progress |
| launch_err | output | 1 | One-cycle pulse for a dropped launch |
| dispatch_active | output | 1 | At least one kernel outstanding |
| pend_valid | output | 1 | Pending queue not empty |
| pend_id | output | $clog2(SLOTS) | Identifier at the queue head |
| pend_pop | input | 1 | Remove the queue head |
| rel_valid | input | 1 | Release strobe |
| rel_id | input | $clog2(SLOTS) | Slot to release |
| slot_sel | input | $clog2(SLOTS) | Slot to display |
| slot_live | output | 1 | Selected slot is live |
| slot_wg_x | output | DIM_W | Selected slot, x count |
| slot_wg_y | output | DIM_W | Selected slot, y count |
| slot_wg_z | output | DIM_W | Selected slot, z count |
| slot_wg_total | output | 3*DIM_W | Selected slot, total count |

## Verification
The bound checker watches the launch control path on every cycle. After each division it confirms that the quotient is the smallest value whose product with the divisor covers the dividend. It also checks that an accepted launch raises busy and the active flag, that a launch during busy yields an error, that a dropped launch leaves the identifier counter unchanged, and that the outstanding and queue counts stay within the slot count. Only the directed scenarios can show byte-lane placement in the descriptor store, the response latency, the end-to-end counts and totals at the field boundaries, the order of identifiers in the queue, the refusal of a launch into a live slot, and the fact that a second release of the same slot has no effect.

// File: rtl/kl_pkg.sv
package kl_pkg;
   typedef enum logic [1:0] {
      SZ_B1 = 2'd0,
      SZ_B2 = 2'd1,
      SZ_B4 = 2'd2,
      SZ_B8 = 2'd3
   } size_code_e;

   localparam int LAUNCH_ADDR = 0;
   localparam int DESC_BASE   = 8;
   localparam int BUS_BYTES   = 8;
   localparam int NUM_DIMS    = 3;
endpackage

// File: rtl/kl_ceil_div.sv
module kl_ceil_div #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         busy,
   output logic         done,
   output logic [W-1:0] quot,
   output logic [W-1:0] num_q,
   output logic [W-1:0] den_q
);
   localparam int CW = $clog2(W + 1);

   logic [W:0]    rem_q;
   logic [W-1:0]  q_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;
   logic [W:0]    shifted;
   logic          ge;

   assign shifted = {rem_q[W-1:0], q_q[W-1]};
   assign ge      = shifted >= {1'b0, den_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         q_q    <= '0;
         num_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (start) begin
         rem_q  <= '0;
         q_q    <= num;
         num_q  <= num;
         den_q  <= (den == '0) ? W'(1) : den;
         cnt_q  <= CW'(W);
         done_q <= 1'b0;
      end else if (cnt_q != '0) begin
         rem_q  <= ge ? (shifted - {1'b0, den_q}) : shifted;
         q_q    <= {q_q[W-2:0], ge};
         cnt_q  <= cnt_q - 1'b1;
         done_q <= (cnt_q == CW'(1));
      end else begin
         done_q <= 1'b0;
      end
   end

   assign quot = q_q + W'(rem_q != '0);
   assign busy = (cnt_q != '0) | done_q;
   assign done = done_q;
endmodule

// File: rtl/kl_id_fifo.sv
module kl_id_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 3,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic          head_valid,
   output logic [W-1:0]  head_data,
   output logic [CW-1:0] count
);
   logic [W-1:0]  mem_q [DEPTH];
   logic [PW-1:0] wr_q, rd_q;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign do_push = push && (cnt_q < CW'(DEPTH));
   assign do_pop  = pop && (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         if (do_push) begin
            mem_q[wr_q] <= push_data;
            wr_q        <= wr_q + 1'b1;
         end
         if (do_pop) rd_q <= rd_q + 1'b1;
         cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
      end
   end

   assign head_valid = cnt_q != '0;
   assign head_data  = mem_q[rd_q];
   assign count      = cnt_q;
endmodule

// File: rtl/kl_rsp_pipe.sv
module kl_rsp_pipe #(
   parameter int LAT = 2,
   parameter int W   = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_v,
   input  logic [W-1:0] in_d,
   output logic         out_v,
   output logic [W-1:0] out_d
);
   generate
      if (LAT == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_v <= 1'b0;
               out_d <= '0;
            end else begin
               out_v <= in_v;
               out_d <= in_v ? in_d : '0;
            end
         end
      end else begin : g_chain
         logic         v_q [LAT];
         logic [W-1:0] d_q [LAT];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < LAT; s++) begin
                  v_q[s] <= 1'b0;
                  d_q[s] <= '0;
               end
            end else begin
               v_q[0] <= in_v;
               d_q[0] <= in_v ? in_d : '0;
               for (int s = 1; s < LAT; s++) begin
                  v_q[s] <= v_q[s-1];
                  d_q[s] <= d_q[s-1];
               end
            end
         end
         assign out_v = v_q[LAT-1];
         assign out_d = d_q[LAT-1];
      end
   endgenerate
endmodule

// File: rtl/kl_launch_regs.sv
module kl_launch_regs
   import kl_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int DESC_BYTES = 16,
   parameter int SLOTS      = 8,
   parameter int DIM_W      = 16,
   parameter int RSP_LAT    = 2,
   localparam int IDW       = $clog2(SLOTS),
   localparam int TW        = NUM_DIMS * DIM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [63:0]       req_wdata,
   output logic              rsp_valid,
   output logic [63:0]       rsp_rdata,
   output logic              launch_busy,
   output logic              launch_err,
   output logic              dispatch_active,
   output logic              pend_valid,
   output logic [IDW-1:0]    pend_id,
   input  logic              pend_pop,
   input  logic              rel_valid,
   input  logic [IDW-1:0]    rel_id,
   input  logic [IDW-1:0]    slot_sel,
   output logic              slot_live,
   output logic [DIM_W-1:0]  slot_wg_x,
   output logic [DIM_W-1:0]  slot_wg_y,
   output logic [DIM_W-1:0]  slot_wg_z,
   output logic [TW-1:0]     slot_wg_total
);
   localparam int FB  = DIM_W / 8;
   localparam int GOF = 0;
   localparam int WOF = NUM_DIMS * FB;
   localparam int DIW = $clog2(DESC_BYTES);
   localparam int OW  = $clog2(SLOTS + 1);
   localparam int QCW = $clog2(SLOTS + 1);

   generate
      if (DIM_W % 8 != 0 || DIM_W < 8)       begin : g_bad_dim   $error("DIM_W must be a whole number of bytes"); end
      if (DESC_BYTES < 2 * NUM_DIMS * FB)    begin : g_bad_desc  $error("descriptor too small for the grid fields"); end
      if (SLOTS < 2 || (SLOTS & (SLOTS - 1)) != 0) begin : g_bad_slots $error("SLOTS must be a power of two"); end
      if (RSP_LAT < 1)                       begin : g_bad_lat   $error("RSP_LAT must be at least one"); end
      if ((1 << ADDR_W) < DESC_BASE + DESC_BYTES) begin : g_bad_addr $error("window too small"); end
   endgenerate

   // ---------------- descriptor store and address decode ----------------
   logic [7:0]        desc_q [DESC_BYTES];
   logic [ADDR_W-1:0] dofs;
   logic              in_desc;
   logic [ADDR_W:0]   byte_idx [BUS_BYTES];
   logic              byte_ok  [BUS_BYTES];
   logic [63:0]       rd_desc, rd_word;

   assign in_desc = req_addr >= ADDR_W'(DESC_BASE);
   assign dofs    = req_addr - ADDR_W'(DESC_BASE);

   always_comb begin
      for (int i = 0; i < BUS_BYTES; i++) begin
         byte_idx[i] = {1'b0, dofs} + (ADDR_W+1)'(i);
         byte_ok[i]  = in_desc && (i < (32'd1 << req_size)) &&
                       (byte_idx[i] < (ADDR_W+1)'(DESC_BYTES));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < DESC_BYTES; j++) desc_q[j] <= '0;
      end else if (req_valid && req_write) begin
         for (int j = 0; j < DESC_BYTES; j++)
            for (int i = 0; i < BUS_BYTES; i++)
               if (byte_ok[i] && byte_idx[i] == (ADDR_W+1)'(j))
                  desc_q[j] <= req_wdata[8*i +: 8];
      end
   end

   always_comb begin
      rd_desc = '0;
      for (int i = 0; i < BUS_BYTES; i++)
         if (byte_ok[i]) rd_desc[8*i +: 8] = desc_q[byte_idx[i][DIW-1:0]];
   end

   always_comb begin
      if (req_write)                               rd_word = '0;
      else if (req_addr == ADDR_W'(LAUNCH_ADDR))   rd_word = (req_size == SZ_B8) ? {63'd0, dispatch_active} : '0;
      else                                         rd_word = rd_desc;
   end

   kl_rsp_pipe #(.LAT(RSP_LAT), .W(64)) u_rsp (
      .clk(clk), .rst_n(rst_n), .in_v(req_valid), .in_d(rd_word),
      .out_v(rsp_valid), .out_d(rsp_rdata)
   );

   // ---------------- launch control ----------------
   logic             wr_launch, launch_ok, rel_hit;
   logic [IDW-1:0]   id_q, run_id_q;
   logic [SLOTS-1:0] live_q;
   logic [OW-1:0]    out_q;
   logic             err_q;

   assign wr_launch = req_valid && req_write && (req_addr == ADDR_W'(LAUNCH_ADDR));
   assign launch_ok = wr_launch && !launch_busy && !live_q[id_q];
   assign rel_hit   = rel_valid && live_q[rel_id];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         id_q     <= '0;
         run_id_q <= '0;
         live_q   <= '0;
         out_q    <= '0;
         err_q    <= 1'b0;
      end else begin
         err_q <= wr_launch && !launch_ok;
         if (launch_ok) begin
            id_q     <= id_q + 1'b1;
            run_id_q <= id_q;
         end
         for (int s = 0; s < SLOTS; s++) begin
            if (launch_ok && id_q == IDW'(s))    live_q[s] <= 1'b1;
            else if (rel_hit && rel_id == IDW'(s)) live_q[s] <= 1'b0;
         end
         out_q <= out_q + OW'(launch_ok) - OW'(rel_hit);
      end
   end

   assign launch_err      = err_q;
   assign dispatch_active = out_q != '0;

   // ---------------- per-dimension ceiling dividers ----------------
   logic [NUM_DIMS-1:0]            div_busy, div_done;
   logic [NUM_DIMS-1:0][DIM_W-1:0] div_q, div_num, div_den, g_size, w_size;

   generate
      for (genvar d = 0; d < NUM_DIMS; d++) begin : g_dim
         always_comb begin
            for (int b = 0; b < FB; b++) begin
               g_size[d][8*b +: 8] = desc_q[GOF + FB*d + b];
               w_size[d][8*b +: 8] = desc_q[WOF + FB*d + b];
            end
         end
         kl_ceil_div #(.W(DIM_W)) u_div (
            .clk(clk), .rst_n(rst_n), .start(launch_ok),
            .num(g_size[d]), .den(w_size[d]),
            .busy(div_busy[d]), .done(div_done[d]), .quot(div_q[d]),
            .num_q(div_num[d]), .den_q(div_den[d])
         );
      end
   endgenerate

   assign launch_busy = |div_busy;

   // ---------------- slot table ----------------
   logic [DIM_W-1:0] cnt_q [SLOTS][NUM_DIMS];
   logic [TW-1:0]    tot_q [SLOTS];
   logic [TW-1:0]    grid_total;

   assign grid_total = TW'(div_q[0]) * TW'(div_q[1]) * TW'(div_q[2]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SLOTS; s++) begin
            tot_q[s] <= '0;
            for (int d = 0; d < NUM_DIMS; d++) cnt_q[s][d] <= '0;
         end
      end else if (div_done[0]) begin
         tot_q[run_id_q] <= grid_total;
         for (int d = 0; d < NUM_DIMS; d++) cnt_q[run_id_q][d] <= div_q[d];
      end
   end

   assign slot_live     = live_q[slot_sel];
   assign slot_wg_x     = cnt_q[slot_sel][0];
   assign slot_wg_y     = cnt_q[slot_sel][1];
   assign slot_wg_z     = cnt_q[slot_sel][2];
   assign slot_wg_total = tot_q[slot_sel];

   // ---------------- pending-launch queue ----------------
   logic [QCW-1:0] q_count;

   kl_id_fifo #(.DEPTH(SLOTS), .W(IDW)) u_pend (
      .clk(clk), .rst_n(rst_n), .push(div_done[0]), .push_data(run_id_q),
      .pop(pend_pop), .head_valid(pend_valid), .head_data(pend_id), .count(q_count)
   );
endmodule

// File: rtl/kl_launch_regs_chk.sv
module kl_launch_regs_chk #(
   parameter int ADDR_W = 12,
   parameter int SLOTS  = 8,
   parameter int DIM_W  = 16,
   localparam int IDW   = $clog2(SLOTS),
   localparam int OW    = $clog2(SLOTS + 1),
   localparam int PW    = 2 * DIM_W
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic                  req_write,
   input logic [ADDR_W-1:0]     req_addr,
   input logic                  launch_busy,
   input logic                  launch_err,
   input logic                  dispatch_active,
   input logic                  launch_ok,
   input logic [IDW-1:0]        id_q,
   input logic [OW-1:0]         out_q,
   input logic [OW-1:0]         q_count,
   input logic [2:0]            div_done,
   input logic [2:0][DIM_W-1:0] div_q,
   input logic [2:0][DIM_W-1:0] div_num,
   input logic [2:0][DIM_W-1:0] div_den
);
   logic wr0;
   assign wr0 = req_valid && req_write && (req_addr == '0);

   assert_busy_after_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      launch_ok |=> launch_busy);

   assert_holdoff_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0 && launch_busy) |=> launch_err);

   assert_drop_keeps_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
      launch_err |-> $stable(id_q));

   assert_active_on_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
      launch_ok |=> dispatch_active);

   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_q <= OW'(SLOTS));

   assert_queue_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= OW'(SLOTS));

   generate
      for (genvar d = 0; d < 3; d++) begin : g_ceil
         assert_ceil_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
            div_done[d] |->
               (PW'(div_q[d]) * PW'(div_den[d]) >= PW'(div_num[d])) &&
               (div_q[d] == '0 || PW'(div_q[d] - 1'b1) * PW'(div_den[d]) < PW'(div_num[d])));
      end
   endgenerate
endmodule

bind kl_launch_regs kl_launch_regs_chk #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .DIM_W(DIM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .launch_busy(launch_busy), .launch_err(launch_err),
   .dispatch_active(dispatch_active), .launch_ok(launch_ok), .id_q(id_q),
   .out_q(out_q), .q_count(q_count), .div_done(div_done), .div_q(div_q),
   .div_num(div_num), .div_den(div_den)
);

// File: tb/sim_kl_launch_regs.sv
module sim_kl_launch_regs;
   localparam int CLK_PERIOD = 10;
   localparam int LAT   = 2;
   localparam int DIM_W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid;
   logic [63:0] rsp_rdata;
   logic        launch_busy, launch_err, dispatch_active;
   logic        pend_valid;
   logic [2:0]  pend_id;
   logic        pend_pop = 1'b0;
   logic        rel_valid = 1'b0;
   logic [2:0]  rel_id = '0, slot_sel = '0;
   logic        slot_live;
   logic [15:0] slot_wg_x, slot_wg_y, slot_wg_z;
   logic [47:0] slot_wg_total;

   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   kl_launch_regs #(.RSP_LAT(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .launch_busy(launch_busy),
      .launch_err(launch_err), .dispatch_active(dispatch_active),
      .pend_valid(pend_valid), .pend_id(pend_id), .pend_pop(pend_pop),
      .rel_valid(rel_valid), .rel_id(rel_id), .slot_sel(slot_sel),
      .slot_live(slot_live), .slot_wg_x(slot_wg_x), .slot_wg_y(slot_wg_y),
      .slot_wg_z(slot_wg_z), .slot_wg_total(slot_wg_total)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic longint ceil_cnt(input int g, input int w);
      int ww;
      ww = (w == 0) ? 1 : w;
      return longint'((g + ww - 1) / ww);
   endfunction

   task automatic bus(input bit wr, input logic [11:0] a, input logic [1:0] sz,
                      input logic [63:0] wd, output logic [63:0] rd, output int lat);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 20) begin
         @(negedge clk);
         lat++;
      end
      rd = rsp_rdata;
   endtask

   task automatic set_desc(input int gx, gy, gz, wx, wy, wz);
      logic [63:0] rd;
      int lat;
      bus(1'b1, 12'd8, 2'd3, {wx[15:0], gz[15:0], gy[15:0], gx[15:0]}, rd, lat);
      bus(1'b1, 12'd16, 2'd2, {32'd0, wz[15:0], wy[15:0]}, rd, lat);
   endtask

   // returns launch_err and launch_busy sampled the cycle after the write
   task automatic launch(input logic [1:0] sz, input logic [63:0] wd, output bit err, output bit bsy);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 12'd0; req_size = sz; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      err = launch_err;
      bsy = launch_busy;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (launch_busy && n < 100) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic pop_expect(input int id, input string req);
      @(negedge clk);
      chk(pend_valid && pend_id == 3'(id), req, longint'(pend_id), longint'(id));
      pend_pop = 1'b1;
      @(negedge clk);
      pend_pop = 1'b0;
   endtask

   task automatic release_slot(input int id);
      @(negedge clk);
      rel_valid = 1'b1; rel_id = 3'(id);
      @(negedge clk);
      rel_valid = 1'b0;
   endtask

   task automatic read_active(output logic [63:0] v);
      int lat;
      bus(1'b0, 12'd0, 2'd3, 64'd0, v, lat);
   endtask

   task automatic run_grid(input int gx, gy, gz, wx, wy, wz, input int id);
      bit err, bsy;
      int n;
      longint ex, ey, ez;
      set_desc(gx, gy, gz, wx, wy, wz);
      launch(2'd3, 64'h0, err, bsy);
      chk(!err, "R4 launch accepted", longint'(err), 0);
      wait_idle(n);
      pop_expect(id, "R7 queued id");
      ex = ceil_cnt(gx, wx); ey = ceil_cnt(gy, wy); ez = ceil_cnt(gz, wz);
      @(negedge clk);
      slot_sel = 3'(id);
      #1;
      chk(slot_wg_x == 16'(ex) && slot_wg_y == 16'(ey) && slot_wg_z == 16'(ez), "R5 counts",
          longint'({slot_wg_x, slot_wg_y, slot_wg_z}), (ex << 32) | (ey << 16) | ez);
      chk(slot_wg_total == 48'(ex * ey * ez), "R6 total", longint'(slot_wg_total), ex * ey * ez);
      chk(slot_live == 1'b1, "R11 slot live", longint'(slot_live), 1);
   endtask

   task automatic t_reset();
      chk(!launch_busy && !launch_err && !dispatch_active && !pend_valid && !rsp_valid,
          "R10 reset state", longint'({launch_busy, launch_err, dispatch_active, pend_valid, rsp_valid}), 0);
   endtask

   task automatic t_desc_rw();
      logic [63:0] rd;
      int lat;
      bus(1'b1, 12'd8, 2'd3, 64'h1122334455667788, rd, lat);
      chk(lat == LAT && rd == 64'd0, "R1 write response", longint'(lat), LAT);
      bus(1'b0, 12'd8, 2'd3, 64'd0, rd, lat);
      chk(lat == LAT, "R1 read latency", longint'(lat), LAT);
      chk(rd == 64'h1122334455667788, "R2 8-byte readback", longint'(rd), 64'h1122334455667788);
      bus(1'b0, 12'd9, 2'd1, 64'd0, rd, lat);
      chk(rd == 64'h6677, "R2 2-byte lanes", longint'(rd), 64'h6677);
      bus(1'b0, 12'd15, 2'd0, 64'd0, rd, lat);
      chk(rd == 64'h11, "R2 1-byte read", longint'(rd), 64'h11);
      bus(1'b1, 12'd22, 2'd2, 64'hAABBCCDD, rd, lat);
      bus(1'b0, 12'd22, 2'd2, 64'd0, rd, lat);
      chk(rd == 64'hCCDD, "R2 store end clipping", longint'(rd), 64'hCCDD);
   endtask

   task automatic t_launch_reg();
      logic [63:0] rd;
      int lat;
      read_active(rd);
      chk(rd == 64'd0, "R3 idle flag", longint'(rd), 0);
      bus(1'b1, 12'd3, 2'd0, 64'hFF, rd, lat);
      @(negedge clk);
      chk(!launch_busy && !pend_valid && !dispatch_active, "R3 write at 3 ignored",
          longint'({launch_busy, pend_valid, dispatch_active}), 0);
      bus(1'b0, 12'd5, 2'd0, 64'd0, rd, lat);
      chk(rd == 64'd0, "R3 read at 5", longint'(rd), 0);
   endtask

   task automatic t_first_launch();
      logic [63:0] rd;
      bit err, bsy;
      int n;
      set_desc(100, 7, 1, 16, 0, 3);
      launch(2'd0, 64'hDEAD, err, bsy);
      chk(!err && bsy, "R4 launch with arbitrary data", longint'({err, bsy}), 1);
      wait_idle(n);
      chk(n == DIM_W + 1, "R8 busy duration", longint'(n), DIM_W + 1);
      pop_expect(0, "R7 first id");
      slot_sel = 3'd0;
      #1;
      chk(slot_wg_x == 16'd7 && slot_wg_y == 16'd7 && slot_wg_z == 16'd1, "R5 zero wg size as one",
          longint'({slot_wg_x, slot_wg_y, slot_wg_z}), 64'h000700070001);
      chk(slot_wg_total == 48'd49, "R6 product", longint'(slot_wg_total), 49);
      read_active(rd);
      chk(rd == 64'd1, "R3 active flag bit", longint'(rd), 1);
      chk(dispatch_active, "R10 active after launch", longint'(dispatch_active), 1);
   endtask

   task automatic t_boundaries();
      run_grid(65535, 0, 64, 1, 5, 16, 1);
      run_grid(17, 65535, 1, 16, 2, 0, 2);
      run_grid(65535, 65535, 65535, 1, 1, 1, 3);
   endtask

   task automatic t_holdoff();
      bit err, bsy;
      int n;
      set_desc(8, 8, 8, 2, 2, 2);
      launch(2'd3, 64'd0, err, bsy);
      chk(!err && bsy, "R8 first launch", longint'({err, bsy}), 1);
      launch(2'd3, 64'd0, err, bsy);
      chk(err, "R8 launch during busy flagged", longint'(err), 1);
      @(negedge clk);
      chk(!launch_err, "R8 error is a pulse", longint'(launch_err), 0);
      wait_idle(n);
      pop_expect(4, "R7 id 4");
      @(negedge clk);
      chk(!pend_valid, "R8 dropped launch not queued", longint'(pend_valid), 0);
      run_grid(9, 1, 1, 4, 1, 1, 5);
   endtask

   task automatic t_full();
      bit err, bsy;
      run_grid(3, 3, 3, 1, 1, 1, 6);
      run_grid(4, 4, 4, 2, 2, 2, 7);
      launch(2'd3, 64'd0, err, bsy);
      chk(err && !bsy, "R9 live slot refused", longint'({err, bsy}), 2);
      @(negedge clk);
      chk(!pend_valid, "R9 nothing queued", longint'(pend_valid), 0);
      release_slot(0);
      slot_sel = 3'd0;
      #1;
      chk(!slot_live, "R10 release frees slot", longint'(slot_live), 0);
      run_grid(30, 20, 10, 7, 3, 10, 0);
   endtask

   task automatic t_drain();
      logic [63:0] rd;
      release_slot(3);
      release_slot(3);
      for (int s = 0; s < 8; s++) if (s != 3) release_slot(s);
      read_active(rd);
      chk(rd == 64'd0, "R10 idle after all released, double release ignored", longint'(rd), 0);
      chk(!dispatch_active, "R10 active cleared", longint'(dispatch_active), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_desc_rw();
      t_launch_reg();
      t_first_launch();
      t_boundaries();
      t_holdoff();
      t_full();
      t_drain();
      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule